// File: doc/BRIEF.md
# Packet Payload XOR Cipher Stage

This block sits in a packet datapath. Each packet passes through it as a stream of 64-bit words. A packet starts with one or more internal header words. These are words with a nonzero control byte, and they leave the stage unchanged. The Ethernet frame follows. Its first 34 bytes hold the Ethernet header (14 bytes) and an IPv4 header without options (20 bytes). These bytes are also forwarded as they are. Every later frame byte is XORed with a key that software loads into a 32-bit key register. XOR undoes itself, so the same stage encrypts on one side of a link and decrypts on the other.

Frame byte 35 falls inside the fifth frame word. In that word the two most significant byte lanes stay clear and the six lower lanes are XORed. Every packet is treated as IPv4, and the EtherType is never examined.

A small fall-through FIFO on the input separates the upstream and downstream handshakes. The stream rules are as follows:
- Upstream may raise `in_valid` only while `in_ready` is high, and every such cycle moves one word.
- The stage raises `out_valid` only in a cycle where `out_ready` is high, and every such cycle moves one word.
- When the downstream stage holds `out_ready` low, words stay in the FIFO until `in_ready` drops.

Top module: `pkt_xor_stage`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0. The key register resets to zero, so packets sent before any key write leave the stage unchanged.
- R2: A word with a nonzero `in_ctrl` that arrives at the start of a packet is an internal header word. It is forwarded unchanged and does not count as a frame word.
- R3: The first four frame words (frame bytes 1 to 32) are forwarded unchanged. Frame words are the words with `in_ctrl` equal to 0 after the header words.
- R4: In the fifth frame word, bits [63:48] (frame bytes 33 and 34) are unchanged. Bits [47:0] are XORed with bits [47:0] of the keystream {key,key}.
- R5: Frame word six and every later word are XORed with the full keystream {key,key}. In every word, byte lane 0 (bits [63:56]) meets key bits [31:24] and byte lane 3 meets key bits [7:0]. The lower four lanes repeat this pattern.
- R6: A frame word with a nonzero (one-hot end marker) `in_ctrl` is the last word of the packet. It is transformed according to its position, its `out_ctrl` equals its `in_ctrl`, and the next word starts a new packet with header skipping.
- R7: Feeding data that was encrypted with key K back through the stage with the same key K restores the original words.
- R8: `out_valid` is high only when `out_ready` is high. Words leave in arrival order, with none dropped or repeated under any pattern of back-pressure.
- R9: `in_ready` is low whenever the FIFO holds DEPTH-1 or more words. With the default depth of 4 and no draining, exactly 3 words are accepted.
- R10: A key write made while a packet is in flight does not change that packet. It takes effect from the next packet onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_we | input | 1 | Key register write strobe |
| key_wdata | input | 32 | Key value written when `key_we` is high |
| in_data | input | 64 | Input word, byte 1 in bits [63:56] |
| in_ctrl | input | 8 | Input control byte: header marker or end marker |
| in_valid | input | 1 | Input word transfer, only while `in_ready` is high |
| in_ready | output | 1 | Stage can take a word |
| out_data | output | 64 | Output word |
| out_ctrl | output | 8 | Output control byte, equal to the input control byte |
| out_valid | output | 1 | Output word transfer, only while `out_ready` is high |
| out_ready | input | 1 | Downstream can take a word |

## Verification
The bench checks the boundary word against a model built from byte lanes. A design that miscounted the 34-byte offset would XOR byte 33 or 34, or would leave byte 35 clear. The bench sends packets with one to three header words one after another, under random back-pressure. A machine that counted header words as frame words, or that failed to return to header skipping after the end marker, would shift the cipher window in the next packet. It would also corrupt the next packet's header words. The bench fills the FIFO with the output stalled and checks that exactly three words are accepted. It also changes the key in the middle of a packet: a stage that applied a new key at once would corrupt the rest of that packet, and one that never applied it would get the following packet wrong.

// File: rtl/pxs_pkg.sv
package pxs_pkg;
  typedef enum logic [2:0] {
    PX_INIT  = 3'd0,
    PX_SKIP  = 3'd1,
    PX_HDR   = 3'd2,
    PX_BOUND = 3'd3,
    PX_PAY   = 3'd4
  } px_state_e;
endpackage

// File: rtl/pxs_fifo.sv
module pxs_fifo #(
  parameter int DATA_W = 64,
  parameter int CTRL_W = 8,
  parameter int DEPTH  = 4,
  parameter int SLACK  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CTRL_W-1:0] wr_ctrl,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output logic [CTRL_W-1:0] head_ctrl,
  output logic              empty,
  output logic              can_take,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam int LIMIT = DEPTH - SLACK;

  logic [DATA_W-1:0] mem_d [DEPTH];
  logic [CTRL_W-1:0] mem_c [DEPTH];
  logic [PTR_W-1:0]  wp, rp;
  logic [CNT_W-1:0]  cnt;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      mem_d[wp] <= wr_data;
      mem_c[wp] <= wr_ctrl;
    end
  end

  assign head_data = mem_d[rp];
  assign head_ctrl = mem_c[rp];
  assign empty     = (cnt == '0);
  assign can_take  = (cnt < CNT_W'(LIMIT));
  assign count     = cnt;
endmodule

// File: rtl/pxs_seq.sv
module pxs_seq
  import pxs_pkg::*;
#(
  parameter int LANES      = 8,
  parameter int CTRL_W     = 8,
  parameter int SKIP_BYTES = 34
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pop,
  input  logic [CTRL_W-1:0] head_ctrl,
  output px_state_e         state,
  output logic [LANES-1:0]  lane_mask
);
  // Full header words before the boundary word, and clear lanes inside it.
  localparam int HDR_WORDS = SKIP_BYTES / LANES;
  localparam int OFS       = SKIP_BYTES % LANES;
  localparam int CW        = $clog2(HDR_WORDS + 1);

  px_state_e      st, st_nx;
  logic [CW-1:0]  wcnt, wcnt_nx;
  logic           ctl_set;

  assign ctl_set = |head_ctrl;

  always_comb begin
    st_nx   = st;
    wcnt_nx = wcnt;
    case (st)
      PX_INIT: st_nx = PX_SKIP;
      PX_SKIP: if (pop && !ctl_set) begin
        st_nx   = PX_HDR;
        wcnt_nx = CW'(1);
      end
      PX_HDR: if (pop) begin
        if (ctl_set)                          st_nx = PX_SKIP;
        else if (wcnt == CW'(HDR_WORDS - 1))  st_nx = (OFS != 0) ? PX_BOUND : PX_PAY;
        else                                  wcnt_nx = wcnt + 1'b1;
      end
      PX_BOUND: if (pop) st_nx = ctl_set ? PX_SKIP : PX_PAY;
      PX_PAY:   if (pop && ctl_set) st_nx = PX_SKIP;
      default:  st_nx = PX_SKIP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= PX_INIT;
      wcnt <= '0;
    end else begin
      st   <= st_nx;
      wcnt <= wcnt_nx;
    end
  end

  // Lane 0 is the most significant byte of the word.
  for (genvar i = 0; i < LANES; i++) begin : g_mask
    assign lane_mask[i] = (st == PX_PAY) || ((st == PX_BOUND) && (i >= OFS));
  end

  assign state = st;
endmodule

// File: rtl/pxs_key.sv
module pxs_key #(
  parameter int KEY_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_we,
  input  logic [KEY_W-1:0] key_wdata,
  input  logic             between_pkts,
  output logic [KEY_W-1:0] act_key
);
  logic [KEY_W-1:0] key_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_q   <= '0;
      act_key <= '0;
    end else begin
      if (key_we)       key_q   <= key_wdata;
      if (between_pkts) act_key <= key_q;
    end
  end
endmodule

// File: rtl/pkt_xor_stage.sv
module pkt_xor_stage
  import pxs_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int KEY_W      = 32,
  parameter int DEPTH      = 4,
  parameter int SKIP_BYTES = 34
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                key_we,
  input  logic [KEY_W-1:0]    key_wdata,
  input  logic [DATA_W-1:0]   in_data,
  input  logic [DATA_W/8-1:0] in_ctrl,
  input  logic                in_valid,
  output logic                in_ready,
  output logic [DATA_W-1:0]   out_data,
  output logic [DATA_W/8-1:0] out_ctrl,
  output logic                out_valid,
  input  logic                out_ready
);
  localparam int LANES  = DATA_W / 8;
  localparam int CTRL_W = LANES;
  localparam int REPS   = DATA_W / KEY_W;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] head_data;
  logic [CTRL_W-1:0] head_ctrl;
  logic              fifo_empty;
  logic [CNT_W-1:0]  fifo_cnt;
  logic              push, pop;
  px_state_e         state;
  logic [LANES-1:0]  lane_mask;
  logic [KEY_W-1:0]  act_key;
  logic [DATA_W-1:0] kstream;

  assign push = in_valid && in_ready;
  assign pop  = !fifo_empty && out_ready && (state != PX_INIT);

  pxs_fifo #(.DATA_W(DATA_W), .CTRL_W(CTRL_W), .DEPTH(DEPTH), .SLACK(1)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .wr_data(in_data), .wr_ctrl(in_ctrl),
    .pop(pop), .head_data(head_data), .head_ctrl(head_ctrl),
    .empty(fifo_empty), .can_take(in_ready), .count(fifo_cnt)
  );

  pxs_seq #(.LANES(LANES), .CTRL_W(CTRL_W), .SKIP_BYTES(SKIP_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .pop(pop), .head_ctrl(head_ctrl),
    .state(state), .lane_mask(lane_mask)
  );

  pxs_key #(.KEY_W(KEY_W)) u_key (
    .clk(clk), .rst_n(rst_n), .key_we(key_we), .key_wdata(key_wdata),
    .between_pkts(state == PX_SKIP), .act_key(act_key)
  );

  assign kstream = {REPS{act_key}};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int HI = DATA_W - 1 - 8*i;
    assign out_data[HI -: 8] = head_data[HI -: 8] ^ (lane_mask[i] ? kstream[HI -: 8] : 8'h00);
  end

  assign out_ctrl  = head_ctrl;
  assign out_valid = pop;
endmodule

// File: rtl/pxs_chk.sv
module pxs_chk
  import pxs_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int KEY_W      = 32,
  parameter int DEPTH      = 4,
  parameter int SKIP_BYTES = 34
) (
  input logic                       clk,
  input logic                       rst_n,
  input px_state_e                  state,
  input logic                       out_valid,
  input logic                       out_ready,
  input logic                       in_ready,
  input logic                       push,
  input logic [DATA_W-1:0]          out_data,
  input logic [DATA_W-1:0]          head_data,
  input logic [$clog2(DEPTH+1)-1:0] fifo_cnt,
  input logic [KEY_W-1:0]           act_key
);
  localparam int OFS = SKIP_BYTES % (DATA_W / 8);
  localparam logic [DATA_W-1:0] KEEP = ~({DATA_W{1'b1}} >> (8*OFS));

  // R1
  init_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PX_INIT) |-> !out_valid);

  // R8
  valid_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_ready);

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(fifo_cnt) >= DEPTH - 1) |-> (!in_ready && !push));

  // R2
  hdr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && state == PX_SKIP) |-> (out_data == head_data));

  // R3
  frame_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && state == PX_HDR) |-> (out_data == head_data));

  // R4
  bound_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && state == PX_BOUND) |-> (((out_data ^ head_data) & KEEP) == '0));

  // R10
  key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != PX_SKIP) |=> $stable(act_key));
endmodule

bind pkt_xor_stage pxs_chk #(
  .DATA_W(DATA_W), .KEY_W(KEY_W), .DEPTH(DEPTH), .SKIP_BYTES(SKIP_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .state(state), .out_valid(out_valid),
  .out_ready(out_ready), .in_ready(in_ready), .push(push), .out_data(out_data),
  .head_data(head_data), .fifo_cnt(fifo_cnt), .act_key(act_key)
);

// File: tb/sim_pkt_xor_stage.sv
`timescale 1ns/1ps
module sim_pkt_xor_stage;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        key_we = 1'b0;
  logic [31:0] key_wdata = '0;
  logic [63:0] in_data = '0;
  logic [7:0]  in_ctrl = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] out_data;
  logic [7:0]  out_ctrl;
  logic        out_valid;
  logic        out_ready = 1'b0;

  always #10 clk = ~clk;

  pkt_xor_stage u0 (
    .clk(clk), .rst_n(rst_n), .key_we(key_we), .key_wdata(key_wdata),
    .in_data(in_data), .in_ctrl(in_ctrl), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_ctrl(out_ctrl), .out_valid(out_valid), .out_ready(out_ready)
  );

  int checks = 0, errors = 0;
  int wp = 0, rp = 0;
  int rdy_mode = 0;   // 0 stall, 1 always ready, 2 random
  bit done = 0;
  logic [63:0] exp_d [0:8191];
  logic [7:0]  exp_c [0:8191];
  string       exp_r [0:8191];

  function automatic logic [63:0] cipher(input logic [63:0] w, input int idx, input logic [31:0] k);
    logic [63:0] ks;
    ks = {k, k};
    if (idx < 4)       return w;
    else if (idx == 4) return {w[63:48], w[47:0] ^ ks[47:0]};
    else               return w ^ ks;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Sink: set ready at negedge, sample away from the edge.
  initial begin
    forever begin
      @(negedge clk);
      out_ready = (rdy_mode == 1) ? 1'b1 : (rdy_mode == 2) ? 1'($urandom % 2) : 1'b0;
      #5;
      if (rst_n && out_valid) begin
        if (rp >= wp) begin
          check(0, "R8", "extra word", out_data, 64'h0);
        end else begin
          check(out_data == exp_d[rp] && out_ctrl == exp_c[rp], exp_r[rp], "word data",
                {out_ctrl, out_data[55:0]}, {exp_c[rp], exp_d[rp][55:0]});
          if (out_data != exp_d[rp])
            $display("  full data: actual %h expected %h", out_data, exp_d[rp]);
          rp++;
        end
      end
    end
  end

  task automatic put_word(input logic [63:0] d, input logic [7:0] c,
                          input logic [63:0] ed, input string r);
    exp_d[wp] = ed; exp_c[wp] = c; exp_r[wp] = r; wp++;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_data = d; in_ctrl = c; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic write_key(input logic [31:0] k);
    @(negedge clk);
    key_we = 1'b1; key_wdata = k;
    @(negedge clk);
    key_we = 1'b0;
  endtask

  task automatic drain();
    while (rp != wp) @(negedge clk);
  endtask

  // dec=1: input is the encrypted form, the expected output is the plain word (R7).
  task automatic send_pkt(input int nhdr, input int nfr, input logic [31:0] k,
                          input string tag_ov, input bit dec,
                          input int split, input logic [31:0] newk);
    for (int h = 0; h < nhdr; h++) begin
      logic [63:0] d;
      d = {$urandom, $urandom};
      put_word(d, 8'hFF, d, (tag_ov != "") ? tag_ov : "R2");
    end
    for (int i = 0; i < nfr; i++) begin
      logic [63:0] p;
      logic [7:0]  c;
      string       t;
      p = {$urandom, $urandom};
      c = (i == nfr - 1) ? (8'h01 << ($urandom % 8)) : 8'h00;
      if (tag_ov != "")      t = tag_ov;
      else if (i == nfr - 1) t = "R6";
      else if (i < 4)        t = "R3";
      else if (i == 4)       t = "R4";
      else                   t = "R5";
      if (dec) put_word(cipher(p, i, k), c, p, t);
      else     put_word(p, c, cipher(p, i, k), t);
      if (i == split) begin
        drain();
        write_key(newk);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    // R1: reset state
    check(in_ready == 1'b1, "R1", "in_ready after reset", 64'(in_ready), 64'd1);
    check(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 64'd0);

    // R1: zero key passes everything
    rdy_mode = 1;
    send_pkt(1, 9, 32'h0, "R1", 0, -1, 0);
    drain();

    // R4/R5: fixed key, directed then random back-pressure
    write_key(32'hA5C3_1E77);
    send_pkt(2, 8, 32'hA5C3_1E77, "", 0, -1, 0);
    rdy_mode = 2;
    for (int n = 0; n < 25; n++) begin
      logic [31:0] k;
      if (n % 5 == 0) begin
        k = $urandom;
        write_key(k);
      end
      send_pkt(1 + ($urandom % 3), 8 + ($urandom % 12), k, "", 0, -1, 0);
    end
    rdy_mode = 1;
    drain();

    // R7: decrypt with the same key
    write_key(32'h1357_9BDF);
    send_pkt(1, 10, 32'h1357_9BDF, "R7", 1, -1, 0);
    drain();

    // R9: fill with the output stalled
    rdy_mode = 0;
    @(negedge clk); @(negedge clk);
    begin
      int acc;
      acc = 0;
      for (int a = 0; a < 6; a++) begin
        @(negedge clk);
        if (in_ready) begin
          logic [63:0] d;
          d = {$urandom, $urandom};
          in_data = d; in_ctrl = 8'hFF; in_valid = 1'b1;
          exp_d[wp] = d; exp_c[wp] = 8'hFF; exp_r[wp] = "R2"; wp++;
          acc++;
        end else begin
          in_valid = 1'b0;
        end
      end
      in_valid = 1'b0;
      check(acc == 3, "R9", "words accepted while stalled", 64'(acc), 64'd3);
      check(in_ready == 1'b0, "R9", "in_ready when nearly full", 64'(in_ready), 64'd0);
      check(out_valid == 1'b0, "R8", "out_valid with ready low", 64'(out_valid), 64'd0);
    end
    rdy_mode = 2;
    send_pkt(0, 9, 32'h1357_9BDF, "", 0, -1, 0);
    rdy_mode = 1;
    drain();

    // R10: key change after frame word 6 leaves; rest of packet keeps old key
    send_pkt(1, 12, 32'h1357_9BDF, "R10", 0, 5, 32'hDEAD_0042);
    send_pkt(1, 10, 32'hDEAD_0042, "R10", 0, -1, 0);
    drain();
    repeat (5) @(negedge clk);

    // R8: every word came out exactly once
    check(rp == wp, "R8", "words delivered", 64'(rp), 64'(wp));
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule